// File: doc/BRIEF.md
# Deferred-Commit Preset Register Store

This block holds the persistent settings of a four-channel digitally controlled potentiometer: four bytes per channel, sixteen in all. A serial bus front end hands it a store request when the final acknowledge of a store command has gone out. The request is a host byte for one register, a copy of one channel's current wiper setting, or a copy of all four wiper settings into the same register index of every channel. The request is held until the bus stop condition. It is then either vetoed by the write-protect pin or launched into a timed write cycle. The new contents appear when that cycle ends.

While a write cycle runs, the block raises a busy flag. The front end uses it to withhold its address acknowledge, which gives the host a way to poll for completion. Reads and register-to-wiper loads need no write cycle, so a combinational row port serves them: one register index of all four channels at once. A second port always shows register 0 of each channel, which the wiper logic loads after reset. Reset stands for power-up. It does not clear the stored bytes, and it restarts two delay counters that mark when reads and when stores become permitted.

Top module: `nvs_store`

## Requirements
- R1: The store holds 4 bytes for each of 4 channels. `row_o` shows, combinationally, register `rd_reg_i` of every channel, with channel p in bits [8p+7:8p], whether or not a write cycle is running.
- R2: An accepted request with `cmd_op_i` = 0 stores `cmd_data_i` into register `cmd_reg_i` of channel `cmd_pot_i`.
- R3: With `cmd_op_i` = 1, the byte of `wiper_i` for channel `cmd_pot_i`, as sampled in the accept cycle, is stored into that channel's register `cmd_reg_i`. Later changes of `wiper_i` have no effect.
- R4: With `cmd_op_i` = 2, all four bytes of `wiper_i`, sampled in the accept cycle, are stored into register `cmd_reg_i` of their own channels in a single write cycle.
- R5: Nothing changes before `stop_i`. `busy_o` goes high in the cycle after the stop and stays high for exactly WR_CYCLES cycles. The stored contents still read the old value during that time and show the new value from the cycle in which `busy_o` falls.
- R6: If `wp_n_i` is low in the cycle of the stop, the held request is dropped, no register changes and `busy_o` stays low.
- R7: A `start_i` between the accept and the stop discards the held request, so the following stop does nothing.
- R8: `cmd_valid_i` is ignored while `busy_o` is high and before `wr_ready_o` is high. A start or stop during a write cycle neither cancels nor repeats it.
- R9: After reset is released, `rd_ready_o` rises after exactly RD_DLY clock edges and `wr_ready_o` rises after exactly WR_DLY edges. Both stay high until the next reset, and both are low during reset with `busy_o` low.
- R10: The stored bytes survive reset, and `preset_o` shows register 0 of every channel, in the same lane order as `row_o`, while reset is held and afterwards.
- R11: A stop with no held request starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, models power-up |
| wp_n_i | input | 1 | Write-protect pin, low vetoes every store |
| cmd_valid_i | input | 1 | Store request strobe, given at the final acknowledge |
| cmd_op_i | input | 2 | 0 host byte, 1 copy one wiper, 2 copy all wipers, 3 none |
| cmd_pot_i | input | 2 | Channel index |
| cmd_reg_i | input | 2 | Register index within the channel |
| cmd_data_i | input | 8 | Host data byte |
| wiper_i | input | 32 | Current wiper settings, channel p in bits [8p+7:8p] |
| start_i | input | 1 | Bus start condition seen |
| stop_i | input | 1 | Bus stop condition seen |
| rd_reg_i | input | 2 | Register index for the row read port |
| row_o | output | 32 | Selected register of all four channels |
| preset_o | output | 32 | Register 0 of all four channels |
| busy_o | output | 1 | Write cycle in progress |
| rd_ready_o | output | 1 | Read delay after power-up has expired |
| wr_ready_o | output | 1 | Write delay after power-up has expired |

## Verification
The bench builds the store with a 20-cycle write cycle, an 8-cycle read delay and a 30-cycle write delay, in place of the millisecond-scale defaults. With these values it can count every busy cycle of each store and see both power-up thresholds within the same run. It can also fill all sixteen registers and still exercise veto, discard, the global copy, and requests made during a write cycle. A second reset late in the run, after every byte has a known value, shows that the contents persist across power-up.

// File: rtl/nvs_pkg.sv
`timescale 1ns/1ps
package nvs_pkg;
    localparam int NUM_POTS     = 4;
    localparam int REGS_PER_POT = 4;
    localparam int DATA_W       = 8;
    localparam int POT_W        = $clog2(NUM_POTS);
    localparam int REG_W        = $clog2(REGS_PER_POT);
    localparam int ROW_W        = NUM_POTS * DATA_W;

    typedef enum logic [1:0] {
        OP_STORE_HOST = 2'd0,
        OP_SAVE_ONE   = 2'd1,
        OP_SAVE_ALL   = 2'd2,
        OP_NONE       = 2'd3
    } nv_op_e;

    typedef enum logic [1:0] {
        JS_IDLE   = 2'd0,
        JS_HELD   = 2'd1,
        JS_FLIGHT = 2'd2
    } job_state_e;

    typedef struct packed {
        logic [NUM_POTS-1:0] lanes;
        logic [REG_W-1:0]    reg_idx;
        logic [ROW_W-1:0]    data;
    } nv_job_t;

    function automatic logic op_is_store(nv_op_e op);
        return op != OP_NONE;
    endfunction

    // Turn a request into lane enables plus a full row of data.
    function automatic nv_job_t make_job(nv_op_e op, logic [POT_W-1:0] pot,
                                         logic [REG_W-1:0] ridx,
                                         logic [DATA_W-1:0] host_byte,
                                         logic [ROW_W-1:0] wipers);
        nv_job_t j;
        j.reg_idx = ridx;
        j.lanes   = '0;
        j.data    = wipers;
        case (op)
            OP_STORE_HOST: begin
                j.lanes[pot] = 1'b1;
                j.data       = {NUM_POTS{host_byte}};
            end
            OP_SAVE_ONE: j.lanes[pot] = 1'b1;
            OP_SAVE_ALL: j.lanes      = '1;
            default:     j.lanes      = '0;
        endcase
        return j;
    endfunction
endpackage

// File: rtl/nvs_powerup.sv
`timescale 1ns/1ps
module nvs_powerup #(
    parameter int unsigned RD_DLY = 125000,
    parameter int unsigned WR_DLY = 625000
) (
    input  logic clk,
    input  logic rst,
    output logic rd_ready_o,
    output logic wr_ready_o
);
    localparam int unsigned CW = $clog2(WR_DLY + 1);

    logic [CW-1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst)
            age_q <= '0;
        else if (age_q != CW'(WR_DLY))
            age_q <= age_q + 1'b1;
    end

    assign rd_ready_o = (age_q >= CW'(RD_DLY));
    assign wr_ready_o = (age_q == CW'(WR_DLY));
endmodule

// File: rtl/nvs_busy_timer.sv
`timescale 1ns/1ps
module nvs_busy_timer #(
    parameter int unsigned CYCLES = 625000
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic busy_o,
    output logic last_o
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (load_i)
            left_q <= CW'(CYCLES);
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign busy_o = (left_q != '0);
    assign last_o = (left_q == CW'(1));
endmodule

// File: rtl/nvs_job_ctl.sv
`timescale 1ns/1ps
module nvs_job_ctl
    import nvs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    accept_i,
    input  nv_job_t job_i,
    input  logic    start_i,
    input  logic    stop_i,
    input  logic    wp_n_i,
    input  logic    last_i,
    output logic    launch_o,
    output logic    commit_o,
    output nv_job_t job_o
);
    job_state_e state_q;
    nv_job_t    job_q;

    assign launch_o = (state_q == JS_HELD) && stop_i && wp_n_i;
    assign commit_o = (state_q == JS_FLIGHT) && last_i;
    assign job_o    = job_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= JS_IDLE;
        end else begin
            case (state_q)
                JS_FLIGHT: if (last_i) state_q <= JS_IDLE;
                default: begin
                    if (stop_i)
                        state_q <= launch_o ? JS_FLIGHT : JS_IDLE;
                    else if (start_i)
                        state_q <= JS_IDLE;
                    else if (accept_i)
                        state_q <= JS_HELD;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            job_q <= '0;
        else if (accept_i && state_q != JS_FLIGHT && !stop_i && !start_i)
            job_q <= job_i;
    end
endmodule

// File: rtl/nvs_array.sv
`timescale 1ns/1ps
module nvs_array
    import nvs_pkg::*;
(
    input  logic             clk,
    input  logic             we_i,
    input  nv_job_t          job_i,
    input  logic [REG_W-1:0] rd_reg_i,
    output logic [ROW_W-1:0] row_o,
    output logic [ROW_W-1:0] preset_o
);
    // Persistent cells: deliberately not cleared by reset.
    for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
        logic [DATA_W-1:0] cell_q [REGS_PER_POT];

        always_ff @(posedge clk) begin
            if (we_i && job_i.lanes[p])
                cell_q[job_i.reg_idx] <= job_i.data[p*DATA_W +: DATA_W];
        end

        assign row_o[p*DATA_W +: DATA_W]    = cell_q[rd_reg_i];
        assign preset_o[p*DATA_W +: DATA_W] = cell_q[0];
    end
endmodule

// File: rtl/nvs_store.sv
`timescale 1ns/1ps
module nvs_store
    import nvs_pkg::*;
#(
    parameter int unsigned WR_CYCLES = 625000,
    parameter int unsigned RD_DLY    = 125000,
    parameter int unsigned WR_DLY    = 625000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wp_n_i,
    input  logic             cmd_valid_i,
    input  logic [1:0]       cmd_op_i,
    input  logic [POT_W-1:0] cmd_pot_i,
    input  logic [REG_W-1:0] cmd_reg_i,
    input  logic [DATA_W-1:0] cmd_data_i,
    input  logic [ROW_W-1:0] wiper_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [REG_W-1:0] rd_reg_i,
    output logic [ROW_W-1:0] row_o,
    output logic [ROW_W-1:0] preset_o,
    output logic             busy_o,
    output logic             rd_ready_o,
    output logic             wr_ready_o
);
    nv_op_e  op;
    nv_job_t new_job;
    nv_job_t cur_job;
    logic    accept;
    logic    launch;
    logic    commit;
    logic    last;

    assign op      = nv_op_e'(cmd_op_i);
    assign new_job = make_job(op, cmd_pot_i, cmd_reg_i, cmd_data_i, wiper_i);
    assign accept  = cmd_valid_i && wr_ready_o && !busy_o && op_is_store(op);

    nvs_powerup #(.RD_DLY(RD_DLY), .WR_DLY(WR_DLY)) u_pwr (
        .clk        (clk),
        .rst        (rst),
        .rd_ready_o (rd_ready_o),
        .wr_ready_o (wr_ready_o)
    );

    nvs_job_ctl u_job (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .job_i    (new_job),
        .start_i  (start_i),
        .stop_i   (stop_i),
        .wp_n_i   (wp_n_i),
        .last_i   (last),
        .launch_o (launch),
        .commit_o (commit),
        .job_o    (cur_job)
    );

    nvs_busy_timer #(.CYCLES(WR_CYCLES)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .load_i (launch),
        .busy_o (busy_o),
        .last_o (last)
    );

    nvs_array u_arr (
        .clk      (clk),
        .we_i     (commit),
        .job_i    (cur_job),
        .rd_reg_i (rd_reg_i),
        .row_o    (row_o),
        .preset_o (preset_o)
    );
endmodule

// File: rtl/nvs_store_chk.sv
`timescale 1ns/1ps
module nvs_store_chk #(
    parameter int unsigned WR_CYCLES = 625000
) (
    input logic clk,
    input logic rst,
    input logic stop_i,
    input logic wp_n_i,
    input logic busy_o,
    input logic rd_ready_o,
    input logic wr_ready_o
);
    localparam int unsigned RW = $clog2(WR_CYCLES + 1) + 1;

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !busy_o)
            run_q <= '0;
        else
            run_q <= run_q + 1'b1;
    end

    p_busy_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(stop_i));

    p_busy_len_r5: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (run_q < RW'(WR_CYCLES)));

    p_wp_veto_r6: assert property (@(posedge clk) disable iff (rst)
        (stop_i && !wp_n_i && !busy_o) |=> !busy_o);

    p_busy_gated_r8: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> wr_ready_o);

    p_ready_order_r9: assert property (@(posedge clk) disable iff (rst)
        wr_ready_o |-> rd_ready_o);

    p_ready_hold_r9: assert property (@(posedge clk) disable iff (rst)
        rd_ready_o |=> rd_ready_o);
endmodule

bind nvs_store nvs_store_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (.*);

// File: tb/tb_nvs_store.sv
`timescale 1ns/1ps
module tb_nvs_store;
    localparam int WC = 20;
    localparam int RD = 8;
    localparam int WD = 30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wp_n_i = 1'b1;
    logic        cmd_valid_i = 1'b0;
    logic [1:0]  cmd_op_i = '0;
    logic [1:0]  cmd_pot_i = '0;
    logic [1:0]  cmd_reg_i = '0;
    logic [7:0]  cmd_data_i = '0;
    logic [31:0] wiper_i = '0;
    logic        start_i = 1'b0;
    logic        stop_i = 1'b0;
    logic [1:0]  rd_reg_i;
    logic [31:0] row_o, preset_o;
    logic        busy_o, rd_ready_o, wr_ready_o;

    always #4 clk = ~clk;

    nvs_store #(.WR_CYCLES(WC), .RD_DLY(RD), .WR_DLY(WD)) dut (.*);

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    logic [7:0] mdl [4][4];

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    typedef struct {
        logic [1:0]  idx;
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    function automatic logic [31:0] mrow(input int r);
        return {mdl[3][r], mdl[2][r], mdl[1][r], mdl[0][r]};
    endfunction

    task automatic check_val(input logic [31:0] got, input logic [31:0] want, input string tag);
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    // Monitor: owns the read port, pops expectations and compares.
    initial begin
        rd_reg_i = '0;
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                rd_reg_i = it.idx;
                #1;
                check_val(row_o, it.val, it.tag);
            end
        end
    end

    task automatic check_row(input int r, input string tag);
        exp_t it;
        it.idx = 2'(r);
        it.val = mrow(r);
        it.tag = tag;
        exp_q.push_back(it);
        while (exp_q.size() != 0) @(negedge clk);
        #2;
    endtask

    task automatic send_cmd(input int op, input int pot, input int r, input logic [7:0] d);
        @(negedge clk);
        cmd_valid_i = 1'b1; cmd_op_i = 2'(op); cmd_pot_i = 2'(pot);
        cmd_reg_i = 2'(r); cmd_data_i = d;
        @(negedge clk);
        cmd_valid_i = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R9 reset state
        check_val({29'd0, busy_o, rd_ready_o, wr_ready_o}, 32'd0, "R9 reset flags");
        rst = 1'b0;
        while (cyc != RD - 1) @(negedge clk);
        check_val({31'd0, rd_ready_o}, 32'd0, "R9 read not ready yet");
        @(negedge clk);
        check_val({31'd0, rd_ready_o}, 32'd1, "R9 read ready after delay");
        // R8: request before write-ready is ignored
        send_cmd(0, 0, 0, 8'hEE);
        pulse_stop();
        check_val({31'd0, busy_o}, 32'd0, "R8 early request ignored");
        while (!wr_ready_o) @(negedge clk);
        check_val(32'(cyc), 32'(WD), "R9 write ready edge count");

        // R2: fill all sixteen registers, R5 busy length on the first one
        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 4; r++) begin
                logic [7:0] v;
                v = 8'((p + 1) * 16 + r * 3 + 1);
                send_cmd(0, p, r, v);
                pulse_stop();
                if (p == 0 && r == 0) begin
                    n = 0;
                    while (busy_o) begin n++; @(negedge clk); end
                    check_val(32'(n), 32'(WC), "R5 busy length");
                end
                wait_idle();
                mdl[p][r] = v;
            end
        end
        for (int r = 0; r < 4; r++) check_row(r, "R1 R2 row after fill");

        // R5: deferral until stop, old value during busy
        send_cmd(0, 1, 2, 8'hA5);
        repeat (5) @(negedge clk);
        check_val({31'd0, busy_o}, 32'd0, "R5 no busy before stop");
        check_row(2, "R5 unchanged before stop");
        pulse_stop();
        check_val({31'd0, busy_o}, 32'd1, "R5 busy after stop");
        check_row(2, "R5 old value during busy");
        wait_idle();
        mdl[1][2] = 8'hA5;
        check_row(2, "R5 new value after busy");

        // R6: write-protect veto
        wp_n_i = 1'b0;
        send_cmd(0, 3, 1, 8'h3C);
        pulse_stop();
        check_val({31'd0, busy_o}, 32'd0, "R6 no busy under protect");
        wp_n_i = 1'b1;
        check_row(1, "R6 register unchanged");

        // R7: start discards held request
        send_cmd(0, 2, 0, 8'h5A);
        pulse_start();
        pulse_stop();
        check_val({31'd0, busy_o}, 32'd0, "R7 no busy after discard");
        check_row(0, "R7 register unchanged");

        // R11: stop alone
        pulse_stop();
        check_val({31'd0, busy_o}, 32'd0, "R11 bare stop");

        // R3: single wiper copy sampled at accept
        wiper_i = 32'h5D4C3B2A;
        send_cmd(1, 2, 3, 8'h00);
        wiper_i = 32'hFFFF_FFFF;
        pulse_stop();
        wait_idle();
        mdl[2][3] = 8'h4C;
        check_row(3, "R3 single wiper copy");

        // R4: global copy into register 0
        wiper_i = 32'hC4B3A291;
        send_cmd(2, 0, 0, 8'h00);
        wiper_i = 32'h0;
        pulse_stop();
        wait_idle();
        mdl[0][0] = 8'h91; mdl[1][0] = 8'hA2; mdl[2][0] = 8'hB3; mdl[3][0] = 8'hC4;
        check_row(0, "R4 global copy");
        check_val(preset_o, mrow(0), "R4 R10 preset after global copy");

        // R8: requests, start and stop during a write cycle
        send_cmd(0, 0, 1, 8'h77);
        pulse_stop();
        send_cmd(0, 2, 2, 8'h99);
        pulse_start();
        pulse_stop();
        wait_idle();
        mdl[0][1] = 8'h77;
        @(negedge clk);
        check_val({31'd0, busy_o}, 32'd0, "R8 no second cycle");
        check_row(1, "R8 in-flight write kept");
        check_row(2, "R8 request during busy ignored");

        // R10: persistence across reset
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check_val(preset_o, mrow(0), "R10 preset during reset");
        check_val({30'd0, rd_ready_o, wr_ready_o}, 32'd0, "R9 ready cleared by reset");
        @(negedge clk); rst = 1'b0;
        for (int r = 0; r < 4; r++) check_row(r, "R10 row after reset");

        finish_run();
    end
endmodule